// File: doc/BRIEF.md
# Reciprocal estimator

The block returns a coarse approximation of 1/x in one clock. It serves as the seed for an iterative reciprocal. A mode input picks how the 32-bit operand is read. In float mode it is an IEEE-754 single-precision value. In fixed mode it is an unsigned fraction, where bit 31 carries weight one half.

Both modes normalise the significant bits into a value a in [0.5, 1). The top eight bits below the leading one select one of 256 slots, q = floor(a·512), with q in 256..511. The slot holds the rounded value of 256/((q+0.5)/512) as a nine-bit integer s in 256..511. These slot values are computed when the design is elaborated, not stored as literals. Float results also get a sign and an exponent, and the special operands are sorted out before the table is used. A strobe qualifies the operand. The result and three sticky-free flag pulses (invalid, divide-by-zero, underflow) appear one cycle later together with a valid output.

Top module: `recip_est_unit`

## Requirements
- R1: Float mode, exponent field 255 with non-zero fraction (NaN): result 0x7FC00000. Invalid flag is set only when fraction bit 22 is 0 (signalling NaN).
- R2: Float mode, exponent 255 with zero fraction (infinity): result is zero carrying the operand's sign bit, with no flags.
- R3: Float mode, exponent 0 with zero fraction: result is infinity (exponent 255, fraction 0) carrying the operand's sign, with the divide-by-zero flag set.
- R4: Float mode, exponent 253 or 254 (magnitude at least 2^126): result is signed zero, with the underflow flag set.
- R5: Float mode, any other operand (subnormals included): sign bit copied, exponent = (253 − exponent field) mod 256, fraction = {s[7:0], 15 zero bits}, with no flags. Here s = floor((2^19 + d)/(2d)) with d = 2q+1 and q = 256 + fraction bits 22:15.
- R6: Fixed mode, operand bit 31 clear: result 0xFFFFFFFF, with no flags.
- R7: Fixed mode, bit 31 set: result = {1, s[7:0], 23 zero bits} with q = 256 + operand bits 30:23, with no flags. Bits 22:0 of the operand have no effect.
- R8: Result, flags and valid output register one cycle after a strobe. A cycle with no strobe drives valid and all flags low the next cycle while the result holds. Back-to-back strobes give back-to-back results.
- R9: Reset (active low, asynchronous) clears valid, result and all flags.
- R10: All 256 table slots produce the value given by the R5 formula, every value lies in 256..511, and values never rise as the slot index rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| mode_fixed | input | 1 | 1 = unsigned fixed-point fraction, 0 = single precision |
| operand | input | 32 | Value to estimate the reciprocal of |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 32 | Estimate |
| flag_invalid | output | 1 | Signalling NaN seen |
| flag_divzero | output | 1 | Zero operand |
| flag_underflow | output | 1 | Operand magnitude at least 2^126 |

## Verification
The only state is the output register, so a wrong stored value shows at the ports in the cycle right after the strobe that caused it. A stuck valid or a flag that outlives its strobe appears one cycle later, when the idle cycle should have cleared it. A wrong table slot shows only for operands that select that slot, so every slot is swept in fixed mode. A wrong special-case ordering shows as a wrong result paired with a flag, and the result-to-flag pairing is checked on every cycle.

// File: rtl/recip_est_pkg.sv
package recip_est_pkg;

    localparam int WORD_W  = 32;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;

    // Exponent field of 2^126 and the base of the reflected exponent
    localparam int UF_EXP_MIN   = 253;
    localparam int RES_EXP_BASE = 253;

    typedef struct packed {
        logic inv;
        logic dz;
        logic uf;
    } est_flags_t;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] result;
        est_flags_t        flags;
    } est_state_t;

    // Rounded (half up) value of 2^(2w+2) / (2q+1), the scaled reciprocal
    // of the slot midpoint (q + 0.5) / 2^(w+1).
    function automatic int unsigned est_entry(input int unsigned q,
                                              input int unsigned idx_w);
        int unsigned num;
        int unsigned den;
        num = 32'd1 << (2 * idx_w + 2);
        den = 2 * q + 1;
        return (2 * num + den) / (2 * den);
    endfunction

endpackage

// File: rtl/recip_est_lut.sv
module recip_est_lut
    import recip_est_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] est_frac
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int LO    = 1 << IDX_W;
    localparam int HI    = (1 << (IDX_W + 1)) - 1;

    logic [IDX_W:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam int unsigned VAL = est_entry(DEPTH + g, IDX_W);
        assign rom[g] = (IDX_W+1)'(VAL);
    end

    logic [IDX_W:0] sel;
    assign sel      = rom[idx];
    assign est_frac = sel[IDX_W-1:0];

    always_comb begin
        AST_LUT_RANGE: assert (int'(sel) >= LO && int'(sel) <= HI); // R10
    end

endmodule

// File: rtl/recip_est_fp_path.sv
module recip_est_fp_path
    import recip_est_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [WORD_W-1:0] op,
    input  logic [IDX_W-1:0]  est_frac,
    output logic [WORD_W-1:0] res,
    output est_flags_t        flags
);
    localparam int PAD_W = FRAC_W - IDX_W;

    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    logic              ex_max, ex_zero, fr_zero, is_quiet, big;
    logic [EXP_W-1:0]  ex_res;

    assign sgn      = op[WORD_W-1];
    assign ex       = op[WORD_W-2 -: EXP_W];
    assign fr       = op[FRAC_W-1:0];
    assign ex_max   = &ex;
    assign ex_zero  = ~|ex;
    assign fr_zero  = ~|fr;
    assign is_quiet = fr[FRAC_W-1];
    assign big      = ex >= EXP_W'(UF_EXP_MIN);
    assign ex_res   = EXP_W'(RES_EXP_BASE) - ex;

    always_comb begin
        flags = '0;
        if (ex_max && !fr_zero) begin
            res       = {1'b0, {(EXP_W+1){1'b1}}, {(FRAC_W-1){1'b0}}};
            flags.inv = !is_quiet;
        end else if (ex_max) begin
            res = {sgn, {(WORD_W-1){1'b0}}};
        end else if (ex_zero && fr_zero) begin
            res      = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            flags.dz = 1'b1;
        end else if (big) begin
            res      = {sgn, {(WORD_W-1){1'b0}}};
            flags.uf = 1'b1;
        end else begin
            res = {sgn, ex_res, est_frac, {PAD_W{1'b0}}};
        end
    end

endmodule

// File: rtl/recip_est_fx_path.sv
module recip_est_fx_path
    import recip_est_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              lead,
    input  logic [IDX_W-1:0]  est_frac,
    output logic [WORD_W-1:0] res
);
    localparam int PAD_W = WORD_W - 1 - IDX_W;

    always_comb begin
        if (lead) res = {1'b1, est_frac, {PAD_W{1'b0}}};
        else      res = '1;
    end

endmodule

// File: rtl/recip_est_unit.sv
module recip_est_unit
    import recip_est_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              mode_fixed,
    input  logic [WORD_W-1:0] operand,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              flag_invalid,
    output logic              flag_divzero,
    output logic              flag_underflow
);
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  est_frac;
    logic [WORD_W-1:0] fp_res, fx_res;
    est_flags_t        fp_flags;
    est_state_t        st_d, st_q;

    // Fixed mode: slot bits sit under bit 31; float mode: under the hidden one
    assign idx = mode_fixed ? operand[WORD_W-2 -: IDX_W] : operand[FRAC_W-1 -: IDX_W];

    recip_est_lut #(.IDX_W(IDX_W)) u_lut (
        .idx      (idx),
        .est_frac (est_frac)
    );

    recip_est_fp_path #(.IDX_W(IDX_W)) u_fp (
        .op       (operand),
        .est_frac (est_frac),
        .res      (fp_res),
        .flags    (fp_flags)
    );

    recip_est_fx_path #(.IDX_W(IDX_W)) u_fx (
        .lead     (operand[WORD_W-1]),
        .est_frac (est_frac),
        .res      (fx_res)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.flags = '0;
        if (in_valid) begin
            st_d.result = mode_fixed ? fx_res : fp_res;
            st_d.flags  = mode_fixed ? '0 : fp_flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid      = st_q.valid;
    assign result         = st_q.result;
    assign flag_invalid   = st_q.flags.inv;
    assign flag_divzero   = st_q.flags.dz;
    assign flag_underflow = st_q.flags.uf;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !flag_invalid && !flag_divzero && !flag_underflow); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R8
    AST_FIXED_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_fixed) |=> !flag_invalid && !flag_divzero && !flag_underflow); // R6
    AST_INV_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        flag_invalid |-> result == 32'h7FC0_0000); // R1
    AST_DZ_INF: assert property (@(posedge clk) disable iff (!rst_n)
        flag_divzero |-> result[WORD_W-2:0] == 31'h7F80_0000); // R3
    AST_UF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flag_underflow |-> result[WORD_W-2:0] == '0); // R4
    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({flag_invalid, flag_divzero, flag_underflow}) <= 1); // R5

endmodule

// File: tb/sim_recip_est_unit.sv
module sim_recip_est_unit;

    typedef struct packed {
        logic        m;
        logic [31:0] op;
        logic [31:0] res;
        logic [2:0]  flg;   // {invalid, divzero, underflow}
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h3F80_0000, 32'h3F7F_8000, 3'b000, 4'd5},  // R5 1.0
        '{1'b0, 32'hC000_0000, 32'hBEFF_8000, 3'b000, 4'd5},  // R5 -2.0
        '{1'b0, 32'h3FC0_0000, 32'h3F2A_8000, 3'b000, 4'd5},  // R5 1.5
        '{1'b0, 32'h7E00_0000, 32'h00FF_8000, 3'b000, 4'd5},  // R5 exponent 252
        '{1'b0, 32'h0000_0001, 32'h7EFF_8000, 3'b000, 4'd5},  // R5 subnormal
        '{1'b0, 32'h3FFF_FFFF, 32'h3F00_0000, 3'b000, 4'd5},  // R5 last slot
        '{1'b0, 32'h7FC0_0001, 32'h7FC0_0000, 3'b000, 4'd1},  // R1 quiet
        '{1'b0, 32'h7F80_0001, 32'h7FC0_0000, 3'b100, 4'd1},  // R1 signalling
        '{1'b0, 32'hFF80_0010, 32'h7FC0_0000, 3'b100, 4'd1},  // R1 neg signalling
        '{1'b0, 32'hFFC0_0000, 32'h7FC0_0000, 3'b000, 4'd1},  // R1 neg quiet
        '{1'b0, 32'h7F80_0000, 32'h0000_0000, 3'b000, 4'd2},  // R2 +inf
        '{1'b0, 32'hFF80_0000, 32'h8000_0000, 3'b000, 4'd2},  // R2 -inf
        '{1'b0, 32'h0000_0000, 32'h7F80_0000, 3'b010, 4'd3},  // R3 +0
        '{1'b0, 32'h8000_0000, 32'hFF80_0000, 3'b010, 4'd3},  // R3 -0
        '{1'b0, 32'h7E80_0000, 32'h0000_0000, 3'b001, 4'd4},  // R4 2^126
        '{1'b0, 32'hFF7F_FFFF, 32'h8000_0000, 3'b001, 4'd4},  // R4 largest
        '{1'b0, 32'h7E7F_FFFF, 32'h0080_0000, 3'b000, 4'd4},  // R4 just below
        '{1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b000, 4'd6},  // R6
        '{1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 3'b000, 4'd6},  // R6
        '{1'b1, 32'h8000_0000, 32'hFF80_0000, 3'b000, 4'd7},  // R7 first slot
        '{1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 3'b000, 4'd7},  // R7 last slot
        '{1'b1, 32'hC000_0000, 32'hAA80_0000, 3'b000, 4'd7},  // R7 mid slot
        '{1'b1, 32'hC07F_FFFF, 32'hAA80_0000, 3'b000, 4'd7},  // R7 low bits ignored
        '{1'b1, 32'h7F80_0000, 32'hFFFF_FFFF, 3'b000, 4'd6}   // R6 float NaN pattern
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode_fixed = 1'b0;
    logic [31:0] operand = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_invalid, flag_divzero, flag_underflow;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    recip_est_unit u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .mode_fixed     (mode_fixed),
        .operand        (operand),
        .out_valid      (out_valid),
        .result         (result),
        .flag_invalid   (flag_invalid),
        .flag_divzero   (flag_divzero),
        .flag_underflow (flag_underflow)
    );

    function automatic logic [8:0] ref_s(input int idx);
        int d;
        d = 2 * (256 + idx) + 1;
        return 9'((524288 + d) / (2 * d));
    endfunction

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] outs();
        return {out_valid, flag_invalid, flag_divzero, flag_underflow, result};
    endfunction

    task automatic apply(input logic m, input logic [31:0] op);
        @(negedge clk);
        in_valid   = 1'b1;
        mode_fixed = m;
        operand    = op;
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] held;
        logic [8:0]  prev;
        repeat (3) @(negedge clk);
        chk("R9 reset state", outs(), 36'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].m, VECS[i].op);
            chk($sformatf("R%0d vector %0d", VECS[i].req, i), outs(),
                {1'b1, VECS[i].flg, VECS[i].res});
        end

        // R8: idle cycle clears valid and flags, result holds
        apply(1'b0, 32'h0000_0000);
        held = result;
        @(negedge clk);
        chk("R8 idle clears", outs(), {4'b0000, held});

        // R8: back-to-back strobes
        @(negedge clk);
        in_valid = 1'b1; mode_fixed = 1'b0; operand = 32'h7F80_0001;
        @(negedge clk);
        chk("R8 first of pair", outs(), {4'b1100, 32'h7FC0_0000});
        operand = 32'h3F80_0000;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 second of pair", outs(), {4'b1000, 32'h3F7F_8000});

        // R10: sweep every slot in fixed mode, values never rise
        prev = 9'h1FF;
        for (int k = 0; k < 256; k++) begin
            logic [8:0] s;
            s = ref_s(k);
            apply(1'b1, {1'b1, 8'(k), 23'h5A5A5});
            chk($sformatf("R10 slot %0d", k), outs(), {4'b1000, 1'b1, s[7:0], 23'h0});
            chk("R10 range/order", {27'h0, (s >= 9'd256 && s <= prev)}, 36'h1);
            prev = s;
        end

        // R5: float sweep of slots with varied exponent and sign
        for (int k = 0; k < 256; k += 17) begin
            logic [8:0] s;
            logic [7:0] e;
            s = ref_s(k);
            e = 8'(1 + k % 250);
            apply(1'b0, {k[0], e, 8'(k), 15'h1234});
            chk($sformatf("R5 float slot %0d", k), outs(),
                {4'b1000, k[0], 8'(8'd253 - e), s[7:0], 15'h0});
        end

        // R9: reset mid-run clears everything at once
        apply(1'b0, 32'h0000_0000);
        #1 rst_n = 1'b0;
        #1 chk("R9 async reset", outs(), 36'h0);
        @(negedge clk);
        chk("R9 reset holds", outs(), 36'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule